// File: doc/BRIEF.md
# Link Configuration Load Sequencer

This block is a host-side controller that walks a target device through the loading of a configuration image. It talks to the target only through a dword register-access port. On that port it issues one read or one write at a time and waits for the target's acknowledge. The register updates follow a fixed order. The controller turns on the target's configuration clocking and mode, and sends bursts of zero-valued writes to the data register so that the target's clock domain can switch. It then requests configuration, waits for the target to report ready, and starts the transfer. Before it hands control to an external data streamer, it programs a clock-to-data ratio that depends on the image type.

When the streamer reports completion, the controller tears the target down in a fixed order and then checks the target's latched configuration-error flag. It then returns the target to normal clocking and waits for the target to report user mode. Every status wait is a bounded poll: a fixed idle gap separates two reads, and each wait phase has its own maximum number of reads. The outcome is a one-cycle `done` pulse and a result code that stays valid until the next start.

Top module: `cfgload_seq`

## Requirements
- R1: Each register access holds `rd_req` or `wr_req`, together with `addr` and `wdata`, unchanged until the cycle in which `ack` is high. At most one access is outstanding at any time. Read data is taken from `rdata` in the `ack` cycle.
- R2: A `start` pulse is accepted only while idle, and `busy` is high from the cycle after an accepted start until the sequence ends. At the end, `done` pulses for one cycle and `busy` falls. `err_code` keeps its value until the next accepted start. A `start` pulse while busy is ignored.
- R3: A start with `img_partial` high ends at once with `err_code` = 2. It makes no register access and does not raise `busy`.
- R4: The first access is a read of the status register (address parameter `ST_ADDR`). If status bit 20 (enable) is 0, the sequence ends with `err_code` = 1 and makes no write.
- R5: If status bit 18 (ready) is already 1 at that first read, a complete teardown (R10) runs before the normal sequence, and the sequence then continues normally.
- R6: Mode-control bit 1 (clock select) is set by its own read-modify-write. Mode-control bit 0 (mode) is set afterwards by a second, separate read-modify-write.
- R7: A clock-switch step writes 1 into mode-control bits 15:8. It then issues exactly `DUMMY_WRITES` writes of value 0 to the data register. The step runs once after the mode bit is set, once after ready rises, and once in every teardown.
- R8: Program-control bit 0 (configure) is set first. The block then polls until status bit 18 reads 1, runs a clock switch, and only after that sets program-control bit 1 (start transfer).
- R9: Before the streamer is started, mode-control bits 15:8 are set to 8 if the image is compressed, to 4 if it is encrypted but not compressed, and to 1 otherwise. `strm_req` then stays high until the cycle after `strm_done` is sampled high.
- R10: Teardown first clears program-control bit 1 (leaving bit 0 unchanged). It clears bit 0 in a second write, runs a clock switch, and then polls until status bit 18 reads 0.
- R11: After the final teardown, the block reads bit 5 of the uncorrectable-error register and ends with `err_code` = 6 if that bit is set. Otherwise it clears mode-control bits 1:0 and polls until status bits 21 and 24 are both 1, then ends with `err_code` = 0.
- R12: Each poll phase reads status at most `RDY_UP_TRIES`, `RDY_DN_TRIES` or `USER_TRIES` times, for the ready-rise, ready-fall and user-mode phases respectively. At least `POLL_GAP` idle cycles separate two reads. When a phase runs out of reads, the sequence ends with `err_code` = 3, 4 or 5 respectively.
- R13: Every register update is a read followed by a write of the value read, with only the targeted bits changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a load sequence |
| img_compressed | input | 1 | Image is compressed (sampled at start) |
| img_encrypted | input | 1 | Image is encrypted (sampled at start) |
| img_partial | input | 1 | Partial-reconfiguration request (rejected) |
| rd_req | output | 1 | Register read request |
| wr_req | output | 1 | Register write request |
| addr | output | ADDR_W | Register dword address |
| wdata | output | DATA_W | Register write data |
| ack | input | 1 | Access completed this cycle |
| rdata | input | DATA_W | Read data, valid with ack |
| strm_req | output | 1 | Image streamer may run |
| strm_done | input | 1 | Streamer finished |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err_code | output | 3 | Result: 0 ok, 1 no device, 2 partial, 3/4/5 timeout rise/fall/user, 6 latched error |

## Verification
The bench builds the block with `DUMMY_WRITES` = 3, `POLL_GAP` = 2 and read limits of 4, 5 and 6 for the three poll phases. With these values every clock-switch burst can be counted write by write, and every timeout can be reached in a few dozen cycles. Because the three limits differ, each timeout code can be told apart by its exact count of status reads. A register-level model of the target keeps other bits in its mode and program registers, so the bench can check that read-modify-write preserves them. The model can also make ready stick low or high, withhold user mode, or set the latched error flag.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  localparam int ERR_W = 3;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE        = 3'd0,
    ERR_NODEV       = 3'd1,
    ERR_PARTIAL     = 3'd2,
    ERR_TO_RDY_UP   = 3'd3,
    ERR_TO_RDY_DN   = 3'd4,
    ERR_TO_USER     = 3'd5,
    ERR_CFG_LATCHED = 3'd6
  } err_e;

  // status bits
  localparam int ST_RDY_BIT  = 18;
  localparam int ST_EN_BIT   = 20;
  localparam int ST_USR_BIT  = 21;
  localparam int ST_PCLK_BIT = 24;
  // mode-control bits
  localparam int MC_MODE_BIT = 0;
  localparam int MC_CSEL_BIT = 1;
  localparam int MC_RAT_LSB  = 8;
  localparam int MC_RAT_W    = 8;
  // program-control bits
  localparam int PC_CFG_BIT  = 0;
  localparam int PC_XFR_BIT  = 1;
  // uncorrectable-error latched config error
  localparam int UE_CFG_BIT  = 5;

  typedef enum logic [4:0] {
    S_IDLE, S_CHK_RD,
    S_CS_RD, S_CS_WR, S_MD_RD, S_MD_WR,
    S_SW_RD, S_SW_WR, S_SW_DUM,
    S_CFG_RD, S_CFG_WR, S_PL_RD, S_PL_GAP,
    S_XF_RD, S_XF_WR, S_RT_RD, S_RT_WR, S_STREAM,
    S_TD_RD, S_TD_WR1, S_TD_WR2,
    S_UE_RD, S_UC_RD, S_UC_WR, S_FIN
  } seq_state_e;

endpackage

// File: rtl/cfgload_cnt.sv
module cfgload_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         dec,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= init;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> (cnt != '0)); // R12

endmodule

// File: rtl/cfgload_bus.sv
module cfgload_bus #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_wr,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  output logic              op_done,
  output logic [DATA_W-1:0] op_rdata,
  output logic              rd_req,
  output logic              wr_req,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  input  logic              ack,
  input  logic [DATA_W-1:0] rdata
);

  logic pending;
  assign pending = rd_req | wr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req   <= 1'b0;
      wr_req   <= 1'b0;
      addr     <= '0;
      wdata    <= '0;
      op_done  <= 1'b0;
      op_rdata <= '0;
    end else begin
      op_done <= 1'b0;
      if (pending && ack) begin
        rd_req  <= 1'b0;
        wr_req  <= 1'b0;
        op_done <= 1'b1;
        if (rd_req) op_rdata <= rdata;
      end else if (go && !pending) begin
        rd_req <= !go_wr;
        wr_req <= go_wr;
        addr   <= go_addr;
        wdata  <= go_wdata;
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (pending && !ack) |=> (rd_req == $past(rd_req) && wr_req == $past(wr_req)
                          && $stable(addr) && $stable(wdata))); // R1
  AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    go |-> !pending); // R1

endmodule

// File: rtl/cfgload_seq.sv
module cfgload_seq
  import cfgload_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int ST_ADDR      = 0,
  parameter int MODE_ADDR    = 1,
  parameter int DATA_ADDR    = 2,
  parameter int PROG_ADDR    = 3,
  parameter int UERR_ADDR    = 4,
  parameter int DUMMY_WRITES = 244,
  parameter int POLL_GAP     = 10,
  parameter int RDY_UP_TRIES = 1,
  parameter int RDY_DN_TRIES = 1,
  parameter int USER_TRIES   = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              img_compressed,
  input  logic              img_encrypted,
  input  logic              img_partial,
  output logic              rd_req,
  output logic              wr_req,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  input  logic              ack,
  input  logic [DATA_W-1:0] rdata,
  output logic              strm_req,
  input  logic              strm_done,
  output logic              busy,
  output logic              done,
  output logic [ERR_W-1:0]  err_code
);

  localparam int MAX_T = (RDY_UP_TRIES > RDY_DN_TRIES)
                         ? ((RDY_UP_TRIES > USER_TRIES) ? RDY_UP_TRIES : USER_TRIES)
                         : ((RDY_DN_TRIES > USER_TRIES) ? RDY_DN_TRIES : USER_TRIES);
  localparam int TRY_W = $clog2(MAX_T + 1);
  localparam int BUR_W = $clog2(DUMMY_WRITES + 1);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam logic [DATA_W-1:0] RAT_MASK = DATA_W'(((1 << MC_RAT_W) - 1) << MC_RAT_LSB);
  localparam logic [DATA_W-1:0] ONE_RAT  = DATA_W'(1 << MC_RAT_LSB);

  seq_state_e state, sw_ret, pl_ret;
  err_e       pl_err;
  logic [DATA_W-1:0] pl_mask, pl_val, rv;
  logic [MC_RAT_W-1:0] ratio;
  logic td_pre, pend, op_go, op_done;
  logic go_wr;
  logic [ADDR_W-1:0] go_addr;
  logic [DATA_W-1:0] go_wdata;
  logic bus_st;

  logic [BUR_W-1:0] bur_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic [TRY_W-1:0] try_cnt, try_init;
  logic bur_load, bur_dec, gap_load, gap_dec, try_load, try_dec;

  cfgload_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_i (
    .clk, .rst, .go(op_go), .go_wr, .go_addr, .go_wdata,
    .op_done, .op_rdata(rv), .rd_req, .wr_req, .addr, .wdata, .ack, .rdata);

  cfgload_cnt #(.W(BUR_W)) burst_i (.clk, .rst, .load(bur_load),
    .init(BUR_W'(DUMMY_WRITES)), .dec(bur_dec), .cnt(bur_cnt));
  cfgload_cnt #(.W(GAP_W)) gap_i (.clk, .rst, .load(gap_load),
    .init(GAP_W'(POLL_GAP)), .dec(gap_dec), .cnt(gap_cnt));
  cfgload_cnt #(.W(TRY_W)) try_i (.clk, .rst, .load(try_load),
    .init(try_init), .dec(try_dec), .cnt(try_cnt));

  assign bus_st = !(state inside {S_IDLE, S_PL_GAP, S_STREAM, S_FIN});

  assign bur_load = op_done && state == S_SW_WR;
  assign bur_dec  = op_done && state == S_SW_DUM;
  assign gap_load = op_done && state == S_PL_RD;
  assign gap_dec  = state == S_PL_GAP && gap_cnt != '0;
  assign try_load = op_done && (state inside {S_CFG_WR, S_TD_WR2, S_UC_WR});
  assign try_dec  = state == S_PL_GAP && gap_cnt == '0 && try_cnt != TRY_W'(1);

  always_comb begin
    case (state)
      S_CFG_WR: try_init = TRY_W'(RDY_UP_TRIES);
      S_TD_WR2: try_init = TRY_W'(RDY_DN_TRIES);
      default:  try_init = TRY_W'(USER_TRIES);
    endcase
  end

  // access descriptor for the current step
  always_comb begin
    go_wr    = 1'b0;
    go_addr  = ADDR_W'(ST_ADDR);
    go_wdata = '0;
    case (state)
      S_CS_RD, S_MD_RD, S_SW_RD, S_RT_RD, S_UC_RD: go_addr = ADDR_W'(MODE_ADDR);
      S_CFG_RD, S_XF_RD, S_TD_RD:                  go_addr = ADDR_W'(PROG_ADDR);
      S_UE_RD:                                     go_addr = ADDR_W'(UERR_ADDR);
      S_CS_WR: begin go_wr = 1'b1; go_addr = ADDR_W'(MODE_ADDR); go_wdata = rv | (DATA_W'(1) << MC_CSEL_BIT); end
      S_MD_WR: begin go_wr = 1'b1; go_addr = ADDR_W'(MODE_ADDR); go_wdata = rv | (DATA_W'(1) << MC_MODE_BIT); end
      S_SW_WR: begin go_wr = 1'b1; go_addr = ADDR_W'(MODE_ADDR); go_wdata = (rv & ~RAT_MASK) | ONE_RAT; end
      S_SW_DUM: begin go_wr = 1'b1; go_addr = ADDR_W'(DATA_ADDR); go_wdata = '0; end
      S_CFG_WR: begin go_wr = 1'b1; go_addr = ADDR_W'(PROG_ADDR); go_wdata = rv | (DATA_W'(1) << PC_CFG_BIT); end
      S_XF_WR: begin go_wr = 1'b1; go_addr = ADDR_W'(PROG_ADDR); go_wdata = rv | (DATA_W'(1) << PC_XFR_BIT); end
      S_RT_WR: begin go_wr = 1'b1; go_addr = ADDR_W'(MODE_ADDR);
                     go_wdata = (rv & ~RAT_MASK) | (DATA_W'(ratio) << MC_RAT_LSB); end
      S_TD_WR1: begin go_wr = 1'b1; go_addr = ADDR_W'(PROG_ADDR); go_wdata = rv & ~(DATA_W'(1) << PC_XFR_BIT); end
      S_TD_WR2: begin go_wr = 1'b1; go_addr = ADDR_W'(PROG_ADDR);
                      go_wdata = rv & ~((DATA_W'(1) << PC_XFR_BIT) | (DATA_W'(1) << PC_CFG_BIT)); end
      S_UC_WR: begin go_wr = 1'b1; go_addr = ADDR_W'(MODE_ADDR);
                     go_wdata = rv & ~((DATA_W'(1) << MC_CSEL_BIT) | (DATA_W'(1) << MC_MODE_BIT)); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      sw_ret   <= S_IDLE;
      pl_ret   <= S_IDLE;
      pl_err   <= ERR_NONE;
      pl_mask  <= '0;
      pl_val   <= '0;
      ratio    <= '0;
      td_pre   <= 1'b0;
      pend     <= 1'b0;
      op_go    <= 1'b0;
      strm_req <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      op_go <= 1'b0;
      done  <= 1'b0;
      if (op_done)              pend <= 1'b0;
      else if (bus_st && !pend) begin op_go <= 1'b1; pend <= 1'b1; end

      case (state)
        S_IDLE: if (start) begin
          ratio <= img_compressed ? MC_RAT_W'(8) : (img_encrypted ? MC_RAT_W'(4) : MC_RAT_W'(1));
          if (img_partial) begin
            done <= 1'b1; err_code <= ERR_PARTIAL;
          end else begin
            busy <= 1'b1; err_code <= ERR_NONE; state <= S_CHK_RD;
          end
        end
        S_CHK_RD: if (op_done) begin
          if (!rv[ST_EN_BIT]) begin
            state <= S_IDLE; busy <= 1'b0; done <= 1'b1; err_code <= ERR_NODEV;
          end else if (rv[ST_RDY_BIT]) begin
            td_pre <= 1'b1; state <= S_TD_RD;
          end else state <= S_CS_RD;
        end
        S_CS_RD:  if (op_done) state <= S_CS_WR;
        S_CS_WR:  if (op_done) state <= S_MD_RD;
        S_MD_RD:  if (op_done) state <= S_MD_WR;
        S_MD_WR:  if (op_done) begin sw_ret <= S_CFG_RD; state <= S_SW_RD; end
        S_SW_RD:  if (op_done) state <= S_SW_WR;
        S_SW_WR:  if (op_done) state <= S_SW_DUM;
        S_SW_DUM: if (op_done && bur_cnt == BUR_W'(1)) state <= sw_ret;
        S_CFG_RD: if (op_done) state <= S_CFG_WR;
        S_CFG_WR: if (op_done) begin
          pl_mask <= DATA_W'(1) << ST_RDY_BIT; pl_val <= DATA_W'(1) << ST_RDY_BIT;
          pl_err <= ERR_TO_RDY_UP; pl_ret <= S_SW_RD; sw_ret <= S_XF_RD; state <= S_PL_RD;
        end
        S_PL_RD: if (op_done) begin
          if ((rv & pl_mask) == pl_val) state <= pl_ret;
          else                          state <= S_PL_GAP;
        end
        S_PL_GAP: if (gap_cnt == '0) begin
          if (try_cnt == TRY_W'(1)) begin
            state <= S_IDLE; busy <= 1'b0; done <= 1'b1; err_code <= pl_err;
          end else state <= S_PL_RD;
        end
        S_XF_RD:  if (op_done) state <= S_XF_WR;
        S_XF_WR:  if (op_done) state <= S_RT_RD;
        S_RT_RD:  if (op_done) state <= S_RT_WR;
        S_RT_WR:  if (op_done) begin strm_req <= 1'b1; state <= S_STREAM; end
        S_STREAM: if (strm_done) begin strm_req <= 1'b0; td_pre <= 1'b0; state <= S_TD_RD; end
        S_TD_RD:  if (op_done) state <= S_TD_WR1;
        S_TD_WR1: if (op_done) state <= S_TD_WR2;
        S_TD_WR2: if (op_done) begin
          pl_mask <= DATA_W'(1) << ST_RDY_BIT; pl_val <= '0; pl_err <= ERR_TO_RDY_DN;
          pl_ret <= td_pre ? S_CS_RD : S_UE_RD; sw_ret <= S_PL_RD; state <= S_SW_RD;
        end
        S_UE_RD: if (op_done) begin
          if (rv[UE_CFG_BIT]) begin
            state <= S_IDLE; busy <= 1'b0; done <= 1'b1; err_code <= ERR_CFG_LATCHED;
          end else state <= S_UC_RD;
        end
        S_UC_RD: if (op_done) state <= S_UC_WR;
        S_UC_WR: if (op_done) begin
          pl_mask <= (DATA_W'(1) << ST_USR_BIT) | (DATA_W'(1) << ST_PCLK_BIT);
          pl_val  <= (DATA_W'(1) << ST_USR_BIT) | (DATA_W'(1) << ST_PCLK_BIT);
          pl_err <= ERR_TO_USER; pl_ret <= S_FIN; state <= S_PL_RD;
        end
        S_FIN: begin state <= S_IDLE; busy <= 1'b0; done <= 1'b1; err_code <= ERR_NONE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R2
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(err_code)); // R2
  AST_STREAM_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    strm_req |-> (busy && !rd_req && !wr_req)); // R9

endmodule

// File: tb/cfgload_seq_tb.sv
module cfgload_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int DUM = 3;
  localparam int GAP = 2;
  localparam int UPT = 4;
  localparam int DNT = 5;
  localparam int UST = 6;
  localparam logic [AW-1:0] A_ST = 0, A_MODE = 1, A_DATA = 2, A_PROG = 3, A_UE = 4;
  localparam logic [31:0] M0 = 32'hA5A5_0000;
  localparam logic [31:0] P0 = 32'h5A00_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cmp = 1'b0, enc = 1'b0, part = 1'b0;
  logic rd_req, wr_req, ack, strm_req, strm_done, busy, done;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [2:0] err_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgload_seq #(.ADDR_W(AW), .DATA_W(DW), .DUMMY_WRITES(DUM), .POLL_GAP(GAP),
    .RDY_UP_TRIES(UPT), .RDY_DN_TRIES(DNT), .USER_TRIES(UST)) dut_i (
    .clk, .rst, .start, .img_compressed(cmp), .img_encrypted(enc), .img_partial(part),
    .rd_req, .wr_req, .addr, .wdata, .ack, .rdata, .strm_req, .strm_done,
    .busy, .done, .err_code);

  // target model configuration (driven by tasks only)
  logic mdl_clr = 1'b0;
  logic st_en = 1'b1, uerr = 1'b0, user_ok = 1'b1;
  int   rdy_mode = 0; // 0 follows configure bit, 1 stuck low, 2 stuck high
  logic [31:0] prog_init = P0;

  // target model state (driven by model process only)
  logic [31:0] mode_r, prog_r;
  logic [AW-1:0] wl_a [32];
  logic [31:0]   wl_d [32];
  int bl [16];
  int nw, nb, cur_b, n_st, n_ops, sc, last_st, min_sp;
  logic bad_dummy, xfer_rdy;
  logic [7:0] ratio_seen;
  int cyc = 0;

  function automatic logic [31:0] status_f();
    logic [31:0] s;
    logic us;
    s = '0;
    s[20] = st_en;
    s[18] = (rdy_mode == 0) ? prog_r[0] : (rdy_mode == 2);
    us = user_ok && mode_r[1:0] == 2'b00;
    s[21] = us;
    s[24] = us;
    return s;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rst || mdl_clr) begin
      ack <= 1'b0; rdata <= '0; mode_r <= M0; prog_r <= prog_init;
      nw <= 0; nb <= 0; cur_b <= 0; n_st <= 0; n_ops <= 0;
      bad_dummy <= 1'b0; xfer_rdy <= 1'b0; last_st <= -1000; min_sp <= 1000000;
    end else begin
      ack <= 1'b0;
      if ((rd_req || wr_req) && !ack) begin
        ack <= 1'b1;
        n_ops <= n_ops + 1;
        if (rd_req) begin
          case (addr)
            A_ST: begin
              rdata <= status_f(); n_st <= n_st + 1; last_st <= cyc;
              if (cyc - last_st < min_sp) min_sp <= cyc - last_st;
            end
            A_MODE:  rdata <= mode_r;
            A_PROG:  rdata <= prog_r;
            A_UE:    rdata <= uerr ? 32'h0000_0020 : 32'h0;
            default: rdata <= '0;
          endcase
        end else if (addr == A_DATA) begin
          cur_b <= cur_b + 1;
          if (wdata != 0) bad_dummy <= 1'b1;
        end else begin
          if (cur_b != 0) begin bl[nb] <= cur_b; nb <= nb + 1; cur_b <= 0; end
          if (nw < 32) begin wl_a[nw] <= addr; wl_d[nw] <= wdata; end
          nw <= nw + 1;
          if (addr == A_MODE) mode_r <= wdata;
          if (addr == A_PROG) begin
            if (wdata[1] && !prog_r[1]) xfer_rdy <= status_f()[18];
            prog_r <= wdata;
          end
        end
      end
    end
  end

  // streamer model
  always @(posedge clk) begin
    if (rst) begin strm_done <= 1'b0; sc <= 0; ratio_seen <= '0; end
    else if (strm_req && !strm_done) begin
      if (sc == 0) ratio_seen <= mode_r[15:8];
      if (sc == 4) begin strm_done <= 1'b1; sc <= 0; end
      else sc <= sc + 1;
    end else strm_done <= 1'b0;
  end

  int checks = 0, errors = 0;
  logic busy_after;
  int n_done;
  logic [2:0] res;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic c, input logic e, input logic p, input bit twice);
    int k;
    @(negedge clk); mdl_clr = 1'b1;
    @(negedge clk); mdl_clr = 1'b0;
    cmp = c; enc = e; part = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
    busy_after = busy;
    n_done = 0;
    k = 0;
    if (twice) begin
      repeat (15) begin @(negedge clk); if (done) n_done++; end
      start = 1'b1; @(negedge clk); start = 1'b0;
      if (done) n_done++;
    end
    while (!done && k < 5000) begin @(negedge clk); k++; end
    if (done) n_done++;
    chk(k < 5000, "R2 sequence did not end", k, 5000);
    res = err_code;
    chk(!busy, "R2 busy low at done", busy, 0);
    repeat (6) begin @(negedge clk); if (done) n_done++; end
    chk(err_code == res, "R2 result held after done", err_code, res);
  endtask

  task automatic t_reset();
    chk(!busy && !done && err_code == 0, "R2 reset outputs", {busy, done, err_code}, 0);
    chk(!rd_req && !wr_req && !strm_req, "R1 reset requests", {rd_req, wr_req, strm_req}, 0);
  endtask

  function automatic logic [31:0] exp_w(int i, logic [7:0] r);
    case (i)
      0: return M0 | 32'h2;      1: return M0 | 32'h3;
      2: return M0 | 32'h103;    3: return P0 | 32'h1;
      4: return M0 | 32'h103;    5: return P0 | 32'h3;
      6: return M0 | {16'h0, r, 8'h03};
      7: return P0 | 32'h1;      8: return P0;
      9: return M0 | 32'h103;    default: return M0 | 32'h100;
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_a(int i);
    return (i == 3 || i == 5 || i == 7 || i == 8) ? A_PROG : A_MODE;
  endfunction

  task automatic t_normal(input logic c, input logic e, input logic [7:0] r, input bit full);
    rdy_mode = 0; st_en = 1; uerr = 0; user_ok = 1; prog_init = P0;
    run(c, e, 1'b0, 1'b0);
    chk(res == 0, "R11 ok result", res, 0);
    chk(ratio_seen == r, "R9 ratio field at stream", ratio_seen, r);
    chk(!strm_req, "R9 stream request dropped", strm_req, 0);
    if (full) begin
      chk(busy_after, "R2 busy after start", busy_after, 1);
      chk(n_done == 1, "R2 one done pulse", n_done, 1);
      chk(nw == 11, "R13 write count", nw, 11);
      for (int i = 0; i < 11; i++) begin
        chk(wl_a[i] == exp_a(i) && wl_d[i] == exp_w(i, r),
            (i < 2) ? "R6 mode order" : (i == 3 || i == 5) ? "R8 program sequence" :
            (i == 7 || i == 8) ? "R10 teardown order" : (i == 10) ? "R11 mode cleared" : "R13 rmw value",
            wl_d[i], exp_w(i, r));
      end
      chk(nb == 3, "R7 burst count", nb, 3);
      for (int i = 0; i < 3; i++) chk(bl[i] == DUM, "R7 burst length", bl[i], DUM);
      chk(!bad_dummy, "R7 dummy data zero", bad_dummy, 0);
      chk(xfer_rdy, "R8 start transfer after ready", xfer_rdy, 1);
      chk(n_st == 4, "R12 one read per satisfied poll", n_st, 4);
    end
  endtask

  task automatic t_partial();
    rdy_mode = 0; st_en = 1; uerr = 0; user_ok = 1; prog_init = P0;
    run(1'b0, 1'b0, 1'b1, 1'b0);
    chk(res == 2, "R3 partial code", res, 2);
    chk(n_ops == 0, "R3 no access", n_ops, 0);
    chk(!busy_after, "R3 busy stays low", busy_after, 0);
  endtask

  task automatic t_nodev();
    rdy_mode = 0; st_en = 0; uerr = 0; user_ok = 1; prog_init = P0;
    run(1'b0, 1'b0, 1'b0, 1'b0);
    chk(res == 1, "R4 no device code", res, 1);
    chk(nw == 0 && n_st == 1, "R4 single status read, no write", {nw[15:0], n_st[15:0]}, 32'h0000_0001);
    st_en = 1;
  endtask

  task automatic t_pretd();
    rdy_mode = 0; st_en = 1; uerr = 0; user_ok = 1; prog_init = P0 | 32'h1;
    run(1'b0, 1'b0, 1'b0, 1'b0);
    chk(res == 0, "R5 result after pre-teardown", res, 0);
    chk(nw == 14, "R5 write count", nw, 14);
    chk(wl_a[0] == A_PROG && wl_d[0] == (P0 | 32'h1), "R5 first clears transfer", wl_d[0], P0 | 32'h1);
    chk(wl_a[1] == A_PROG && wl_d[1] == P0, "R5 then clears configure", wl_d[1], P0);
    chk(nb == 4, "R5 extra clock switch", nb, 4);
    prog_init = P0;
  endtask

  task automatic t_timeouts();
    st_en = 1; uerr = 0; user_ok = 1; prog_init = P0;
    rdy_mode = 1;
    run(1'b0, 1'b0, 1'b0, 1'b0);
    chk(res == 3, "R12 ready-rise timeout code", res, 3);
    chk(n_st == 1 + UPT, "R12 ready-rise read count", n_st, 1 + UPT);
    chk(min_sp > GAP, "R12 poll gap", min_sp, GAP + 1);
    rdy_mode = 2; prog_init = P0 | 32'h1;
    run(1'b0, 1'b0, 1'b0, 1'b0);
    chk(res == 4, "R12 ready-fall timeout code", res, 4);
    chk(n_st == 1 + DNT, "R12 ready-fall read count", n_st, 1 + DNT);
    rdy_mode = 0; prog_init = P0; user_ok = 0;
    run(1'b0, 1'b0, 1'b0, 1'b0);
    chk(res == 5, "R12 user-mode timeout code", res, 5);
    chk(n_st == 3 + UST, "R12 user-mode read count", n_st, 3 + UST);
    user_ok = 1;
  endtask

  task automatic t_latched();
    rdy_mode = 0; st_en = 1; uerr = 1; user_ok = 1; prog_init = P0;
    run(1'b0, 1'b0, 1'b0, 1'b0);
    chk(res == 6, "R11 latched error code", res, 6);
    chk(nw == 10, "R11 mode not cleared on error", nw, 10);
    uerr = 0;
  endtask

  task automatic t_restart();
    rdy_mode = 0; st_en = 1; uerr = 0; user_ok = 1; prog_init = P0;
    run(1'b0, 1'b0, 1'b0, 1'b1);
    chk(n_done == 1, "R2 start while busy ignored", n_done, 1);
    chk(nw == 11 && res == 0, "R2 single sequence", nw, 11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_normal(1'b0, 1'b0, 8'd1, 1'b1);
    t_normal(1'b0, 1'b1, 8'd4, 1'b0);
    t_normal(1'b1, 1'b0, 8'd8, 1'b0);
    t_normal(1'b1, 1'b1, 8'd8, 1'b0);
    t_partial();
    t_nodev();
    t_pretd();
    t_timeouts();
    t_latched();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired: cycles=%0d expected<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule